// File: doc/BRIEF.md
# Deferred-Fault Commit and Clear Unit

This block keeps the per-register deferred-fault flags of two register banks, one for integer registers and one for floating-point registers, together with a small array of fault log slots. When a speculative load meets a fault it does not trap. Instead the fault is recorded: the destination register's flag is set and, if logging is switched on, one log slot captures the register number, its bank and the faulting address.

Two operations resolve these deferred faults later. A clear removes the flag of one destination register, or of a whole bank when the wildcard is selected. A commit does the same, but it first samples whether any selected flag was set, and if so and logging is on it requests a commit exception. Either operation also drops the log slots that describe the registers it touched. Availability inputs for the upper and lower halves of a bank limit what a wildcard may reach. The register access check is made elsewhere and arrives as an input. Every operation takes one clock cycle. All log slots are compared in parallel.

Top module: `dfu_commit_unit`

## Requirements
- R1: After reset every flag in both banks is 0, every log slot reads as invalid with its bank bit, register number and address all 0, and `commit_exc` is 0.
- R2: A cycle with `rec_en`=1 and `op_en`=0 sets, at the next clock edge, the flag of register `rec_reg` in the bank chosen by `rec_fp` (0 = integer bank, 1 = floating-point bank).
- R3: When such a record happens while `ctl_valid` and `ctl_log_en` are both 1, the lowest-numbered invalid slot becomes valid with `rec_fp`, `rec_reg` and `rec_addr`. With logging off, or with every slot valid, no slot changes.
- R4: `rec_en` has no effect in a cycle where `op_en` is 1.
- R5: An operation with `op_all`=0 clears only the flag of `op_reg` in the bank chosen by `op_fp`. The other bank and every other flag keep their values.
- R6: An operation with `op_all`=1 clears register flags 0 to 31 of the chosen bank only if `lo_avail` is 1, and flags 32 to 63 only if `hi_avail` is 1.
- R7: The selected flags are cleared whether or not any of them was set before the operation.
- R8: `commit_exc` is 1 for exactly the cycle after a commit (`op_kind`=1) with `op_access_ok`=1, `ctl_valid`=1 and `ctl_log_en`=1 whose sampled flag was 1. For a wildcard the sampled value is (`hi_avail` and any upper flag set) or (`lo_avail` and any lower flag set). The sample is taken before the clear.
- R9: Slot invalidation zeroes the valid bit, bank bit, register number and address of each valid slot whose bank equals `op_fp` and whose register equals `op_reg`, or of every such slot when `op_all`=1.
- R10: A clear (`op_kind`=0) invalidates matching slots whenever logging is on, even if no flag was set. A commit invalidates them only when its sampled flag was 1. With logging off no slot is invalidated.
- R11: An operation with `op_access_ok`=0 changes no flag and no slot and raises no exception.
- R12: All matching slots are invalidated in the same cycle, whatever their number and position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Fault control register is valid |
| ctl_log_en | input | 1 | Fault logging enable |
| rec_en | input | 1 | Record a deferred fault |
| rec_fp | input | 1 | Bank of the recorded register (1 = floating point) |
| rec_reg | input | 6 | Recorded destination register |
| rec_addr | input | 32 | Faulting address to log |
| op_en | input | 1 | Resolve operation request |
| op_kind | input | 1 | 0 = clear, 1 = commit |
| op_fp | input | 1 | Bank the operation targets |
| op_all | input | 1 | Wildcard: every available register |
| op_reg | input | 6 | Target register when not wildcard |
| op_access_ok | input | 1 | Target register passed the access check |
| hi_avail | input | 1 | Upper half of the bank is available |
| lo_avail | input | 1 | Lower half of the bank is available |
| gr_flags | output | 64 | Integer bank fault flags |
| fr_flags | output | 64 | Floating-point bank fault flags |
| slot_valid | output | 16 | Log slot valid bits |
| slot_fp | output | 16 | Log slot bank bits |
| slot_reg_flat | output | 96 | Log slot register numbers, slot i at bits 6i+5:6i |
| slot_addr_flat | output | 512 | Log slot addresses, slot i at bits 32i+31:32i |
| commit_exc | output | 1 | One-cycle commit exception request |

## Verification
All state of the block is visible at the ports: the flags, the slots and the exception pulse. A wrong mask from the operation decode therefore shows up one clock after the operation, as a flag that survives or a neighbour that vanishes. A wrong match or priority in the slot array appears in the same cycle as the wrong slot contents. A pending sample taken after the clear instead of before it shows up as a missing exception pulse on the very next cycle. The reference model is compared on every clock, so a corrupted slot or flag is caught on the first cycle it differs, not when it is later consumed.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
  typedef enum logic {
    OP_CLEAR  = 1'b0,
    OP_COMMIT = 1'b1
  } dfu_op_e;
endpackage

// File: rtl/dfu_op_decode.sv
module dfu_op_decode
  import dfu_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             op_en,
  input  logic             op_kind,
  input  logic             op_fp,
  input  logic             op_all,
  input  logic [REG_W-1:0] op_reg,
  input  logic             op_access_ok,
  input  logic             hi_avail,
  input  logic             lo_avail,
  input  logic             log_on,
  input  logic [NREG-1:0]  gr_flags,
  input  logic [NREG-1:0]  fr_flags,
  output logic [NREG-1:0]  gr_clr,
  output logic [NREG-1:0]  fr_clr,
  output logic             pending,
  output logic             inval_en,
  output logic             exc_req
);
  localparam int HALF = NREG / 2;

  // Mask of every register a wildcard may reach
  function automatic logic [NREG-1:0] half_mask(input logic hi, input logic lo);
    return {{HALF{hi}}, {HALF{lo}}};
  endfunction

  function automatic logic [NREG-1:0] one_reg(input logic [REG_W-1:0] r);
    return {{(NREG-1){1'b0}}, 1'b1} << r;
  endfunction

  logic            act;
  logic [NREG-1:0] sel_mask;
  logic [NREG-1:0] bank;

  assign act      = op_en & op_access_ok;
  assign bank     = op_fp ? fr_flags : gr_flags;
  assign sel_mask = op_all ? half_mask(hi_avail, lo_avail) : one_reg(op_reg);
  assign pending  = act & (|(bank & sel_mask));
  assign gr_clr   = (act & ~op_fp) ? sel_mask : '0;
  assign fr_clr   = (act & op_fp) ? sel_mask : '0;
  assign exc_req  = act & (op_kind == OP_COMMIT) & log_on & pending;
  assign inval_en = act & log_on & ((op_kind == OP_CLEAR) | pending);
endmodule

// File: rtl/dfu_flag_bank.sv
module dfu_flag_bank #(
  parameter int NREG = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] clr_mask,
  input  logic [NREG-1:0] set_mask,
  output logic [NREG-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  // R7
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((flags & $past(clr_mask)) == '0));

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((flags & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/dfu_slot_array.sv
module dfu_slot_array #(
  parameter int NSLOT  = 16,
  parameter int REG_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inval_en,
  input  logic                    op_fp,
  input  logic                    op_all,
  input  logic [REG_W-1:0]        op_reg,
  input  logic                    wr_en,
  input  logic                    wr_fp,
  input  logic [REG_W-1:0]        wr_reg,
  input  logic [ADDR_W-1:0]       wr_addr,
  output logic [NSLOT-1:0]        valid,
  output logic [NSLOT-1:0]        fp,
  output logic [NSLOT*REG_W-1:0]  reg_flat,
  output logic [NSLOT*ADDR_W-1:0] addr_flat
);
  logic [NSLOT-1:0] free_vec;
  logic [NSLOT-1:0] wr_sel;
  logic [NSLOT-1:0] kill;

  assign free_vec = ~valid;
  // lowest free slot as a one-hot vector
  assign wr_sel   = wr_en ? (free_vec & (~free_vec + 1'b1)) : '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [REG_W-1:0]  r_q;
    logic [ADDR_W-1:0] a_q;

    assign kill[i] = inval_en & valid[i] & (fp[i] == op_fp) &
                     (op_all | (r_q == op_reg));

    always_ff @(posedge clk) begin
      if (!rst_n || kill[i]) begin
        valid[i] <= 1'b0;
        fp[i]    <= 1'b0;
        r_q      <= '0;
        a_q      <= '0;
      end else if (wr_sel[i]) begin
        valid[i] <= 1'b1;
        fp[i]    <= wr_fp;
        r_q      <= wr_reg;
        a_q      <= wr_addr;
      end
    end

    assign reg_flat[i*REG_W +: REG_W]    = r_q;
    assign addr_flat[i*ADDR_W +: ADDR_W] = a_q;

    // R9
    slot_killed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill[i] |=> (!valid[i] && a_q == '0 && r_q == '0));
  end

  // R3
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid & ~$past(valid)) <= 1));

  // R3
  fill_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/dfu_commit_unit.sv
module dfu_commit_unit
  import dfu_pkg::*;
#(
  parameter int NREG   = 64,
  parameter int NSLOT  = 16,
  parameter int ADDR_W = 32,
  parameter int REG_W  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_valid,
  input  logic                    ctl_log_en,
  input  logic                    rec_en,
  input  logic                    rec_fp,
  input  logic [REG_W-1:0]        rec_reg,
  input  logic [ADDR_W-1:0]       rec_addr,
  input  logic                    op_en,
  input  logic                    op_kind,
  input  logic                    op_fp,
  input  logic                    op_all,
  input  logic [REG_W-1:0]        op_reg,
  input  logic                    op_access_ok,
  input  logic                    hi_avail,
  input  logic                    lo_avail,
  output logic [NREG-1:0]         gr_flags,
  output logic [NREG-1:0]         fr_flags,
  output logic [NSLOT-1:0]        slot_valid,
  output logic [NSLOT-1:0]        slot_fp,
  output logic [NSLOT*REG_W-1:0]  slot_reg_flat,
  output logic [NSLOT*ADDR_W-1:0] slot_addr_flat,
  output logic                    commit_exc
);
  logic            log_on;
  logic            rec_go;
  logic [NREG-1:0] rec_mask;
  logic [NREG-1:0] gr_clr, fr_clr, gr_set, fr_set;
  logic            pending, inval_en, exc_req;

  assign log_on   = ctl_valid & ctl_log_en;
  assign rec_go   = rec_en & ~op_en;
  assign rec_mask = {{(NREG-1){1'b0}}, 1'b1} << rec_reg;
  assign gr_set   = (rec_go & ~rec_fp) ? rec_mask : '0;
  assign fr_set   = (rec_go & rec_fp) ? rec_mask : '0;

  dfu_op_decode #(.NREG(NREG), .REG_W(REG_W)) u_dec (
    .op_en(op_en), .op_kind(op_kind), .op_fp(op_fp), .op_all(op_all),
    .op_reg(op_reg), .op_access_ok(op_access_ok), .hi_avail(hi_avail),
    .lo_avail(lo_avail), .log_on(log_on), .gr_flags(gr_flags),
    .fr_flags(fr_flags), .gr_clr(gr_clr), .fr_clr(fr_clr),
    .pending(pending), .inval_en(inval_en), .exc_req(exc_req)
  );

  dfu_flag_bank #(.NREG(NREG)) u_gr (
    .clk(clk), .rst_n(rst_n), .clr_mask(gr_clr), .set_mask(gr_set),
    .flags(gr_flags)
  );

  dfu_flag_bank #(.NREG(NREG)) u_fr (
    .clk(clk), .rst_n(rst_n), .clr_mask(fr_clr), .set_mask(fr_set),
    .flags(fr_flags)
  );

  dfu_slot_array #(.NSLOT(NSLOT), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .inval_en(inval_en), .op_fp(op_fp),
    .op_all(op_all), .op_reg(op_reg), .wr_en(rec_go & log_on),
    .wr_fp(rec_fp), .wr_reg(rec_reg), .wr_addr(rec_addr),
    .valid(slot_valid), .fp(slot_fp), .reg_flat(slot_reg_flat),
    .addr_flat(slot_addr_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) commit_exc <= 1'b0;
    else        commit_exc <= exc_req;
  end

  // R8
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_exc |-> $past(op_en && op_kind && op_access_ok && ctl_valid && ctl_log_en));

  // R8
  exc_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_exc |-> !$past(commit_exc) || $past(op_en && op_kind));

  // R11
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !op_access_ok) |=> ($stable(gr_flags) && $stable(fr_flags) &&
                                  $stable(slot_valid) && !commit_exc));

  // R4
  rec_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !op_access_ok && rec_en) |=> $stable(slot_valid));
endmodule

// File: tb/dfu_commit_unit_bench.sv
module dfu_commit_unit_bench;
  localparam int NREG = 64, NSLOT = 16, AW = 32, RW = 6;

  logic clk = 0, rst_n = 0;
  logic ctl_valid, ctl_log_en, rec_en, rec_fp, op_en, op_kind, op_fp, op_all;
  logic op_access_ok, hi_avail, lo_avail;
  logic [RW-1:0] rec_reg, op_reg;
  logic [AW-1:0] rec_addr;
  logic [NREG-1:0] gr_flags, fr_flags;
  logic [NSLOT-1:0] slot_valid, slot_fp;
  logic [NSLOT*RW-1:0] slot_reg_flat;
  logic [NSLOT*AW-1:0] slot_addr_flat;
  logic commit_exc;

  int checks = 0, errors = 0, cycles = 0;

  // reference state
  logic [NREG-1:0] m_gr, m_fr;
  bit m_sv[NSLOT];
  bit m_sf[NSLOT];
  int m_sr[NSLOT];
  logic [AW-1:0] m_sa[NSLOT];
  bit m_exc;

  always #10 clk = ~clk;

  dfu_commit_unit u_dfu_commit_unit (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_log_en(ctl_log_en),
    .rec_en(rec_en), .rec_fp(rec_fp), .rec_reg(rec_reg), .rec_addr(rec_addr),
    .op_en(op_en), .op_kind(op_kind), .op_fp(op_fp), .op_all(op_all),
    .op_reg(op_reg), .op_access_ok(op_access_ok), .hi_avail(hi_avail),
    .lo_avail(lo_avail), .gr_flags(gr_flags), .fr_flags(fr_flags),
    .slot_valid(slot_valid), .slot_fp(slot_fp), .slot_reg_flat(slot_reg_flat),
    .slot_addr_flat(slot_addr_flat), .commit_exc(commit_exc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 100000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    rec_en = 0; rec_fp = 0; rec_reg = 0; rec_addr = 0;
    op_en = 0; op_kind = 0; op_fp = 0; op_all = 0; op_reg = 0;
    op_access_ok = 1; hi_avail = 1; lo_avail = 1;
  endtask

  task automatic model_reset();
    m_gr = '0; m_fr = '0; m_exc = 0;
    for (int i = 0; i < NSLOT; i++) begin
      m_sv[i] = 0; m_sf[i] = 0; m_sr[i] = 0; m_sa[i] = '0;
    end
  endtask

  // behavioural next state from the current inputs
  task automatic model_apply();
    bit logon, pend, inval;
    logic [NREG-1:0] b;
    logon = ctl_valid && ctl_log_en;
    m_exc = 0;
    if (op_en) begin
      if (op_access_ok) begin
        b = op_fp ? m_fr : m_gr;
        if (op_all) pend = (hi_avail && b[63:32] != 0) || (lo_avail && b[31:0] != 0);
        else        pend = b[op_reg];
        if (op_all) begin
          if (hi_avail) b[63:32] = '0;
          if (lo_avail) b[31:0]  = '0;
        end else b[op_reg] = 1'b0;
        if (op_fp) m_fr = b; else m_gr = b;
        m_exc = op_kind && logon && pend;
        inval = logon && (!op_kind || pend);
        if (inval)
          for (int i = 0; i < NSLOT; i++)
            if (m_sv[i] && m_sf[i] == op_fp && (op_all || m_sr[i] == int'(op_reg))) begin
              m_sv[i] = 0; m_sf[i] = 0; m_sr[i] = 0; m_sa[i] = '0;
            end
      end
    end else if (rec_en) begin
      if (rec_fp) m_fr[rec_reg] = 1'b1; else m_gr[rec_reg] = 1'b1;
      if (logon)
        for (int i = 0; i < NSLOT; i++)
          if (!m_sv[i]) begin
            m_sv[i] = 1; m_sf[i] = rec_fp; m_sr[i] = int'(rec_reg); m_sa[i] = rec_addr;
            break;
          end
    end
  endtask

  task automatic compare(string tag);
    logic [NSLOT-1:0] ev, ef;
    logic [NSLOT*RW-1:0] er;
    logic [NSLOT*AW-1:0] ea;
    for (int i = 0; i < NSLOT; i++) begin
      ev[i] = m_sv[i]; ef[i] = m_sf[i];
      er[i*RW +: RW] = RW'(m_sr[i]); ea[i*AW +: AW] = m_sa[i];
    end
    checks++;
    if (gr_flags !== m_gr) begin
      errors++; $display("FAIL %s gr_flags actual %h expected %h", tag, gr_flags, m_gr);
    end
    checks++;
    if (fr_flags !== m_fr) begin
      errors++; $display("FAIL %s fr_flags actual %h expected %h", tag, fr_flags, m_fr);
    end
    checks++;
    if (slot_valid !== ev || slot_fp !== ef || slot_reg_flat !== er || slot_addr_flat !== ea) begin
      errors++;
      $display("FAIL %s slots actual v=%h f=%h r=%h expected v=%h f=%h r=%h",
               tag, slot_valid, slot_fp, slot_reg_flat, ev, ef, er);
    end
    checks++;
    if (commit_exc !== m_exc) begin
      errors++; $display("FAIL %s commit_exc actual %b expected %b", tag, commit_exc, m_exc);
    end
  endtask

  task automatic step(string tag);
    model_apply();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  task automatic rec(bit fp, int r, logic [AW-1:0] a, string tag);
    rec_en = 1; rec_fp = fp; rec_reg = RW'(r); rec_addr = a;
    step(tag);
  endtask

  task automatic op(bit kind, bit fp, bit all, int r, bit acc, bit hi, bit lo, string tag);
    op_en = 1; op_kind = kind; op_fp = fp; op_all = all; op_reg = RW'(r);
    op_access_ok = acc; hi_avail = hi; lo_avail = lo;
    step(tag);
  endtask

  initial begin
    idle();
    ctl_valid = 1; ctl_log_en = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");

    rec(0, 3, 32'hA000_0010, "R2 R3 record GR3");
    rec(1, 40, 32'hB000_0020, "R3 record FR40");
    rec(0, 35, 32'hC000_0030, "R3 record GR35");

    // R4: record alongside a rejected operation
    rec_en = 1; rec_fp = 0; rec_reg = 9; rec_addr = 32'hDEAD_0000;
    op(1, 0, 0, 3, 0, 1, 1, "R4 record ignored under op");
    op(1, 0, 0, 3, 0, 1, 1, "R11 no access commit");
    op(1, 0, 0, 3, 1, 1, 1, "R8 R9 commit pending GR3");
    op(1, 0, 0, 3, 1, 1, 1, "R7 commit with no pending");
    op(0, 1, 0, 41, 1, 1, 1, "R10 clear FR41 no flag");
    op(0, 1, 0, 40, 1, 1, 1, "R5 R10 clear FR40");

    rec(0, 5, 32'h1111_0000, "R3 record GR5");
    rec(0, 6, 32'h2222_0000, "R3 record GR6");
    rec(0, 37, 32'h3333_0000, "R3 record GR37");
    rec(1, 6, 32'h4444_0000, "R3 record FR6");
    op(1, 0, 1, 0, 1, 0, 1, "R6 R12 wildcard commit low only");
    op(1, 0, 1, 0, 1, 0, 1, "R6 R8 wildcard low nothing pending");
    op(1, 0, 1, 0, 1, 1, 0, "R6 R8 wildcard commit high only");
    op(0, 1, 1, 0, 1, 1, 1, "R9 wildcard clear FR bank");

    ctl_log_en = 0;
    rec(0, 12, 32'h5555_0000, "R3 record with logging off");
    op(1, 0, 0, 12, 1, 1, 1, "R8 R10 commit with logging off");
    ctl_log_en = 1;

    for (int k = 0; k < NSLOT + 1; k++)
      rec(k[0], k, 32'h6000_0000 + k, "R3 fill to full");
    op(0, 0, 1, 0, 1, 1, 1, "R12 wildcard clear GR slots");

    for (int k = 0; k < 4000; k++) begin
      ctl_valid  = ($urandom_range(0, 15) != 0);
      ctl_log_en = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 1) == 1) begin
        rec_en = 1; rec_fp = $urandom_range(0, 1);
        rec_reg = RW'($urandom_range(0, 7) + 32 * $urandom_range(0, 1));
        rec_addr = $urandom;
      end
      if ($urandom_range(0, 2) == 0) begin
        op_en = 1; op_kind = $urandom_range(0, 1); op_fp = $urandom_range(0, 1);
        op_all = ($urandom_range(0, 5) == 0);
        op_reg = RW'($urandom_range(0, 7) + 32 * $urandom_range(0, 1));
        op_access_ok = ($urandom_range(0, 7) != 0);
        hi_avail = $urandom_range(0, 1); lo_avail = $urandom_range(0, 1);
      end
      step("R10 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule